// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This block is the control half of a centralized scoreboard for an in-order issue, out-of-order completion pipeline. One decoded instruction per cycle is offered on the instruction port. Each instruction names a functional unit class, a destination register and two source registers. The block decides whether the instruction may issue. It then tracks the instruction through operand read, execution and result write back, and it reports each of those steps as a per-unit pulse. The register file data path is not part of this block. Only the status tables and the hazard decisions are built. Execution is modelled as a latency counter in each unit entry.

There are five functional units. Each unit owns one status entry, so a unit accepts a new instruction only after its current one has written back. The entry holds the destination, the two sources, a ready flag per source and the producing unit of any source that is not yet available. A register result table records which unit will write each register next.

Each hazard is resolved as late as possible:
- A busy unit or a pending destination (WAW) holds the instruction at issue.
- A missing source (RAW) holds the instruction in the operand-read step.
- A register still needed by an earlier instruction that has not yet read it (WAR) holds the result back at write back.

Issue stays in program order. An instruction that is waiting for operands does not block independent instructions issued after it.

Top module: `scoreboard_ctrl`

## Requirements
- R1: `grant_o` is high in a cycle exactly when all of the following hold: `valid_i` is high, `fu_i` is a legal unit code, the selected unit is idle, and `dst_i` has no pending producer. Legal unit codes are 0 integer, 1 FP add, 2 FP multiply, 3 FP divide and 4 FP load; codes 5 to 7 are never granted. `stall_o` is high exactly when `valid_i` is high and `grant_o` is low. The source must hold a stalled instruction.
- R2: A unit's `busy_o` bit rises in the cycle after its grant and stays high up to and including its write-back cycle. An instruction for a busy unit stalls. This includes a unit that is writing back in that same cycle, so a second divide is granted one cycle after the first divide's write back at the earliest.
- R3: An instruction whose destination is pending stalls until the producer writes back. It is granted one cycle after that write back at the earliest.
- R4: A unit pulses `rd_o` in the first cycle in which both of its sources are ready. Sources not pending at issue are ready at once, so the read happens the cycle after the grant. A source produced by another unit becomes ready one cycle after that unit's write back.
- R5: An instruction waiting for operands does not hold back later independent instructions; those may read, execute and write back before it.
- R6: `cmpl_o` pulses exactly LAT cycles after the unit's read cycle. LAT defaults to 1 for integer, 2 for FP add, 5 for FP multiply, 15 for FP divide and 2 for FP load, and each value is a parameter.
- R7: A completed unit does not write back while another unit is still waiting to read a ready source equal to its destination. Its write back comes one cycle after that read at the earliest.
- R8: When no WAR hazard applies, `wb_o` pulses the cycle after `cmpl_o`. Write back makes the unit idle and clears the producer entry of its destination register.
- R9: After reset all units are idle, no destination is pending, and `busy_o`, `rd_o`, `cmpl_o` and `wb_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is offered |
| fu_i | input | 3 | Functional unit code (0 int, 1 add, 2 mul, 3 div, 4 load) |
| dst_i | input | REG_W | Destination register |
| src1_i | input | REG_W | First source register |
| src2_i | input | REG_W | Second source register |
| grant_o | output | 1 | Instruction issues this cycle |
| stall_o | output | 1 | Instruction offered but held |
| busy_o | output | 5 | Per-unit busy status |
| rd_o | output | 5 | Per-unit operand read pulse |
| cmpl_o | output | 5 | Per-unit execution complete pulse |
| wb_o | output | 5 | Per-unit write back pulse |

## Verification
`grant_o` and `stall_o` are combinational in the offered instruction, so they are due in the same cycle the instruction is presented. `busy_o` follows one register later. For a unit with no hazards:
- `rd_o` is due one cycle after the grant.
- `cmpl_o` is due LAT cycles after the read.
- `wb_o` is due one cycle after completion, so write back lands LAT+2 cycles after the grant.

The bench drives inputs just after the rising edge and samples all outputs at the falling edge. A behavioural per-cycle model is compared with every output in every cycle. Directed programs record the cycle of every grant, read and write back, and check the distances between them: LAT+2 for an independent unit, write back plus one for RAW, WAW and a busy divider, and read plus one for WAR.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int NUM_FU = 5;
  localparam int FU_W   = 3;
  localparam int TAGS   = 1 << FU_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RO   = 2'd1,
    ST_EX   = 2'd2,
    ST_WB   = 2'd3
  } fu_st_e;
endpackage

// File: rtl/sbc_fu_entry.sv
module sbc_fu_entry
  import sbc_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int LAT   = 1,
  localparam int CNT_W = $clog2(LAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [REG_W-1:0] src1_i,
  input  logic [REG_W-1:0] src2_i,
  input  logic             rdy1_i,
  input  logic             rdy2_i,
  input  logic [FU_W-1:0]  q1_i,
  input  logic [FU_W-1:0]  q2_i,
  input  logic [TAGS-1:0]  wb_all_i,
  input  logic             war_blk_i,
  output logic             busy_o,
  output logic             in_ro_o,
  output logic [REG_W-1:0] dst_o,
  output logic [REG_W-1:0] src1_o,
  output logic [REG_W-1:0] src2_o,
  output logic             rdy1_o,
  output logic             rdy2_o,
  output logic             rd_o,
  output logic             cmpl_o,
  output logic             wb_o
);
  fu_st_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [FU_W-1:0]  q1_q, q2_q;

  assign busy_o  = (st_q != ST_IDLE);
  assign in_ro_o = (st_q == ST_RO);
  assign rd_o    = in_ro_o && rdy1_o && rdy2_o;
  assign cmpl_o  = (st_q == ST_EX) && (cnt_q == CNT_W'(1));
  assign wb_o    = (st_q == ST_WB) && !war_blk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      dst_o  <= '0;
      src1_o <= '0;
      src2_o <= '0;
      rdy1_o <= 1'b0;
      rdy2_o <= 1'b0;
      q1_q   <= '0;
      q2_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (issue_i) begin
          st_q   <= ST_RO;
          dst_o  <= dst_i;
          src1_o <= src1_i;
          src2_o <= src2_i;
          rdy1_o <= rdy1_i;
          rdy2_o <= rdy2_i;
          q1_q   <= q1_i;
          q2_q   <= q2_i;
        end
        ST_RO: begin
          if (rd_o) begin
            st_q  <= ST_EX;
            cnt_q <= CNT_W'(LAT);
          end else begin
            // producer wrote this cycle: readable from next cycle
            if (!rdy1_o && wb_all_i[q1_q]) rdy1_o <= 1'b1;
            if (!rdy2_o && wb_all_i[q2_q]) rdy2_o <= 1'b1;
          end
        end
        ST_EX: begin
          if (cnt_q == CNT_W'(1)) st_q <= ST_WB;
          else cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_WB: if (!war_blk_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbc_result_table.sv
module sbc_result_table
  import sbc_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [REG_W-1:0] set_reg_i,
  input  logic [FU_W-1:0]  set_tag_i,
  input  logic [TAGS-1:0]  wb_all_i,
  output logic [NREG-1:0]  pend_o,
  output logic [FU_W-1:0]  tag_o [NREG]
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[r] <= 1'b0;
        tag_o[r]  <= '0;
      end else if (set_i && (set_reg_i == REG_W'(r))) begin
        pend_o[r] <= 1'b1;
        tag_o[r]  <= set_tag_i;
      end else if (pend_o[r] && wb_all_i[tag_o[r]]) begin
        pend_o[r] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sbc_war_check.sv
module sbc_war_check
  import sbc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [NUM_FU-1:0] in_ro_i,
  input  logic [NUM_FU-1:0] rdy1_i,
  input  logic [NUM_FU-1:0] rdy2_i,
  input  logic [REG_W-1:0]  dst_i  [NUM_FU],
  input  logic [REG_W-1:0]  src1_i [NUM_FU],
  input  logic [REG_W-1:0]  src2_i [NUM_FU],
  output logic [NUM_FU-1:0] blk_o
);
  for (genvar f = 0; f < NUM_FU; f++) begin : g_wr
    logic [NUM_FU-1:0] hit;
    for (genvar g = 0; g < NUM_FU; g++) begin : g_rd
      if (g == f) begin : g_self
        assign hit[g] = 1'b0;
      end else begin : g_other
        // reader still owes a read of the old value
        assign hit[g] = in_ro_i[g] &&
                        ((rdy1_i[g] && (src1_i[g] == dst_i[f])) ||
                         (rdy2_i[g] && (src2_i[g] == dst_i[f])));
      end
    end
    assign blk_o[f] = |hit;
  end
endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
  import sbc_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 5,
  parameter int LAT_DIV = 15,
  parameter int LAT_LD  = 2,
  localparam int REG_W  = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        fu_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [REG_W-1:0]  src1_i,
  input  logic [REG_W-1:0]  src2_i,
  output logic              grant_o,
  output logic              stall_o,
  output logic [NUM_FU-1:0] busy_o,
  output logic [NUM_FU-1:0] rd_o,
  output logic [NUM_FU-1:0] cmpl_o,
  output logic [NUM_FU-1:0] wb_o
);
  function automatic int lat_of(int f);
    case (f)
      0: return LAT_INT;
      1: return LAT_ADD;
      2: return LAT_MUL;
      3: return LAT_DIV;
      default: return LAT_LD;
    endcase
  endfunction

  logic [NUM_FU-1:0] in_ro, rdy1, rdy2, war_blk, iss;
  logic [REG_W-1:0]  e_dst [NUM_FU];
  logic [REG_W-1:0]  e_s1  [NUM_FU];
  logic [REG_W-1:0]  e_s2  [NUM_FU];
  logic [NREG-1:0]   pend;
  logic [FU_W-1:0]   ptag  [NREG];
  logic [TAGS-1:0]   wb_pad, busy_pad;
  logic              fu_ok, s1_rdy, s2_rdy;

  assign wb_pad   = {{(TAGS-NUM_FU){1'b0}}, wb_o};
  assign busy_pad = {{(TAGS-NUM_FU){1'b0}}, busy_o};
  assign fu_ok    = (fu_i < FU_W'(NUM_FU));

  assign grant_o  = valid_i && fu_ok && !busy_pad[fu_i] && !pend[dst_i];
  assign stall_o  = valid_i && !grant_o;

  // a same-cycle write back counts as available: the read comes later
  assign s1_rdy   = !pend[src1_i] || wb_pad[ptag[src1_i]];
  assign s2_rdy   = !pend[src2_i] || wb_pad[ptag[src2_i]];

  for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
    assign iss[f] = grant_o && (fu_i == FU_W'(f));
    sbc_fu_entry #(
      .REG_W (REG_W),
      .LAT   (lat_of(f))
    ) u_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .issue_i   (iss[f]),
      .dst_i     (dst_i),
      .src1_i    (src1_i),
      .src2_i    (src2_i),
      .rdy1_i    (s1_rdy),
      .rdy2_i    (s2_rdy),
      .q1_i      (ptag[src1_i]),
      .q2_i      (ptag[src2_i]),
      .wb_all_i  (wb_pad),
      .war_blk_i (war_blk[f]),
      .busy_o    (busy_o[f]),
      .in_ro_o   (in_ro[f]),
      .dst_o     (e_dst[f]),
      .src1_o    (e_s1[f]),
      .src2_o    (e_s2[f]),
      .rdy1_o    (rdy1[f]),
      .rdy2_o    (rdy2[f]),
      .rd_o      (rd_o[f]),
      .cmpl_o    (cmpl_o[f]),
      .wb_o      (wb_o[f])
    );
  end

  sbc_war_check #(.REG_W(REG_W)) u_war (
    .in_ro_i (in_ro),
    .rdy1_i  (rdy1),
    .rdy2_i  (rdy2),
    .dst_i   (e_dst),
    .src1_i  (e_s1),
    .src2_i  (e_s2),
    .blk_o   (war_blk)
  );

  sbc_result_table #(.NREG(NREG), .REG_W(REG_W)) u_rtab (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (grant_o),
    .set_reg_i (dst_i),
    .set_tag_i (fu_i),
    .wb_all_i  (wb_pad),
    .pend_o    (pend),
    .tag_o     (ptag)
  );
endmodule

// File: rtl/scoreboard_ctrl_chk.sv
module scoreboard_ctrl_chk
  import sbc_pkg::*;
#(
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 5,
  parameter int LAT_DIV = 15,
  parameter int LAT_LD  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        fu_i,
  input logic              grant_o,
  input logic              stall_o,
  input logic [NUM_FU-1:0] busy_o,
  input logic [NUM_FU-1:0] rd_o,
  input logic [NUM_FU-1:0] cmpl_o,
  input logic [NUM_FU-1:0] wb_o
);
  function automatic int lat_of(int f);
    case (f)
      0: return LAT_INT;
      1: return LAT_ADD;
      2: return LAT_MUL;
      3: return LAT_DIV;
      default: return LAT_LD;
    endcase
  endfunction

  p_grant_stall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, stall_o}) && ((grant_o || stall_o) == valid_i));

  for (genvar f = 0; f < NUM_FU; f++) begin : g_a
    p_grant_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o && (fu_i == 3'(f))) |=> busy_o[f]);

    p_busy_no_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o[f] && (fu_i == 3'(f))) |-> !grant_o);

    p_read_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_o[f] |-> busy_o[f] && !cmpl_o[f] && !wb_o[f]);

    if (lat_of(f) == 1) begin : g_l1
      p_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_o[f] |=> cmpl_o[f]);
    end else begin : g_ln
      p_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_o[f] |=> !cmpl_o[f]);
    end

    p_wb_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_o[f] |=> !busy_o[f]);

    p_cmpl_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmpl_o[f] |=> busy_o[f] && !rd_o[f]);
  end
endmodule

bind scoreboard_ctrl scoreboard_ctrl_chk #(
  .LAT_INT (LAT_INT),
  .LAT_ADD (LAT_ADD),
  .LAT_MUL (LAT_MUL),
  .LAT_DIV (LAT_DIV),
  .LAT_LD  (LAT_LD)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .fu_i    (fu_i),
  .grant_o (grant_o),
  .stall_o (stall_o),
  .busy_o  (busy_o),
  .rd_o    (rd_o),
  .cmpl_o  (cmpl_o),
  .wb_o    (wb_o)
);

// File: tb/scoreboard_ctrl_test.sv
module scoreboard_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 5;
  localparam int LATS [NF] = '{1, 2, 5, 15, 2};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [2:0] fu = 3'd0;
  logic [4:0] dst = 5'd0, s1 = 5'd0, s2 = 5'd0;
  logic       grant, stall;
  logic [4:0] busy, rd, cmpl, wb;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_st [NF], m_cnt [NF], m_dst [NF], m_s1 [NF], m_s2 [NF], m_q1 [NF], m_q2 [NF];
  bit m_r1 [NF], m_r2 [NF];
  bit m_pend [32];
  int m_tag [32];

  // event cycle log
  int g_cyc [NF], rd_cyc [NF], wb_cyc [NF];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scoreboard_ctrl uut (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid), .fu_i (fu),
    .dst_i (dst), .src1_i (s1), .src2_i (s2),
    .grant_o (grant), .stall_o (stall), .busy_o (busy),
    .rd_o (rd), .cmpl_o (cmpl), .wb_o (wb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit [4:0] e_busy, e_rd, e_cmpl, e_wb;
    bit e_grant, e_stall, rdy_a, rdy_b;
    if (!rst_n) begin
      for (int f = 0; f < NF; f++) begin
        m_st[f] = 0; m_cnt[f] = 0; m_r1[f] = 0; m_r2[f] = 0;
      end
      for (int r = 0; r < 32; r++) begin m_pend[r] = 0; m_tag[r] = 0; end
    end else begin
      for (int f = 0; f < NF; f++) begin
        bit war;
        war = 0;
        for (int g = 0; g < NF; g++)
          if (g != f && m_st[g] == 1 &&
              ((m_r1[g] && m_s1[g] == m_dst[f]) || (m_r2[g] && m_s2[g] == m_dst[f])))
            war = 1;
        e_busy[f] = (m_st[f] != 0);
        e_rd[f]   = (m_st[f] == 1) && m_r1[f] && m_r2[f];
        e_cmpl[f] = (m_st[f] == 2) && (m_cnt[f] == 1);
        e_wb[f]   = (m_st[f] == 3) && !war;
      end
      e_grant = valid && (fu < 5) && !e_busy[fu] && !m_pend[dst];
      e_stall = valid && !e_grant;
      // R1 R2 R3 R4 R6 R7 R8: full per-cycle comparison
      chk({grant, stall, busy, rd, cmpl, wb} == {e_grant, e_stall, e_busy, e_rd, e_cmpl, e_wb},
          "R1/R8 per-cycle model",
          int'({grant, stall, busy, rd, cmpl, wb}),
          int'({e_grant, e_stall, e_busy, e_rd, e_cmpl, e_wb}));
      if (grant) g_cyc[fu] = cyc;
      for (int f = 0; f < NF; f++) begin
        if (rd[f]) rd_cyc[f] = cyc;
        if (wb[f]) wb_cyc[f] = cyc;
      end
      // advance model to next cycle
      rdy_a = !m_pend[s1] || e_wb[m_tag[s1]];
      rdy_b = !m_pend[s2] || e_wb[m_tag[s2]];
      for (int f = 0; f < NF; f++) begin
        case (m_st[f])
          1: if (e_rd[f]) begin m_st[f] = 2; m_cnt[f] = LATS[f]; end
             else begin
               if (!m_r1[f] && e_wb[m_q1[f]]) m_r1[f] = 1;
               if (!m_r2[f] && e_wb[m_q2[f]]) m_r2[f] = 1;
             end
          2: if (m_cnt[f] == 1) m_st[f] = 3; else m_cnt[f]--;
          3: if (e_wb[f]) m_st[f] = 0;
          default: ;
        endcase
      end
      for (int r = 0; r < 32; r++)
        if (m_pend[r] && e_wb[m_tag[r]]) m_pend[r] = 0;
      if (e_grant) begin
        m_st[fu] = 1; m_dst[fu] = dst; m_s1[fu] = s1; m_s2[fu] = s2;
        m_r1[fu] = rdy_a; m_r2[fu] = rdy_b;
        m_q1[fu] = m_tag[s1]; m_q2[fu] = m_tag[s2];
        m_pend[dst] = 1; m_tag[dst] = int'(fu);
      end
    end
  end

  task automatic issue(input int f, input int d, input int a, input int b);
    valid = 1'b1; fu = 3'(f); dst = 5'(d); s1 = 5'(a); s2 = 5'(b);
    do begin @(negedge clk); #1; end while (!grant);
    @(posedge clk); #1;
  endtask

  task automatic drain();
    valid = 1'b0;
    do begin @(negedge clk); #1; end while (busy != 0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(busy == 0 && rd == 0 && cmpl == 0 && wb == 0 && !grant, "R9 reset idle",
        int'({busy, rd, cmpl, wb}), 0);
    @(posedge clk); #1;

    // R1: illegal unit code is never granted
    valid = 1'b1; fu = 3'd5; dst = 5'd1;
    @(negedge clk); #1;
    chk(!grant && stall, "R1 illegal code stalls", int'({grant, stall}), 1);
    @(posedge clk); #1; valid = 1'b0;
    @(posedge clk); #1;

    // R6 R8: independent instructions on every unit
    issue(0, 1, 2, 3);
    issue(1, 4, 5, 6);
    issue(2, 7, 8, 9);
    issue(3, 10, 11, 12);
    issue(4, 13, 14, 15);
    drain();
    for (int f = 0; f < NF; f++)
      chk(wb_cyc[f] - g_cyc[f] == LATS[f] + 2, "R6 latency grant-to-wb",
          wb_cyc[f] - g_cyc[f], LATS[f] + 2);

    // R4 R5: RAW wait and an independent instruction passing it
    issue(2, 0, 2, 4);
    issue(1, 2, 0, 4);
    issue(0, 10, 11, 12);
    drain();
    chk(rd_cyc[1] == wb_cyc[2] + 1, "R4 RAW read after wb", rd_cyc[1], wb_cyc[2] + 1);
    chk(wb_cyc[0] < rd_cyc[1], "R5 independent passes waiting", wb_cyc[0], rd_cyc[1]);

    // R3: WAW stall until producer write back
    issue(1, 6, 1, 2);
    issue(0, 6, 3, 4);
    drain();
    chk(g_cyc[0] == wb_cyc[1] + 1, "R3 WAW grant after wb", g_cyc[0], wb_cyc[1] + 1);

    // R2: divider not pipelined
    issue(3, 20, 21, 22);
    issue(3, 23, 24, 25);
    chk(g_cyc[3] == wb_cyc[3] + 1, "R2 second divide after wb", g_cyc[3], wb_cyc[3] + 1);
    drain();

    // R7: WAR delays write back
    issue(3, 0, 2, 4);
    issue(1, 6, 0, 8);
    issue(0, 8, 10, 12);
    drain();
    chk(rd_cyc[1] == wb_cyc[3] + 1, "R4 RAW read after divide wb", rd_cyc[1], wb_cyc[3] + 1);
    chk(wb_cyc[0] == rd_cyc[1] + 1, "R7 WAR wb after read", wb_cyc[0], rd_cyc[1] + 1);
    chk(busy == 0, "R8 all idle after drain", int'(busy), 0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule